// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This unit gathers event conditions from a serial port's transmit path, receive path and clear-to-send modem line into a fourteen-bit sticky status register. Each status bit is paired with a bit in an enable register of the same layout. The single interrupt line is active high and level sensitive. It stays high while any status bit is both set and enabled.

Neighbouring logic presents events on a fourteen-bit input vector, as single-cycle pulses or as levels. A level keeps setting its bit every cycle it is held. The clear-to-send input is asynchronous. It passes through a synchroniser, and each change of the synchronised level sets its own status bit. Software acknowledges events by writing ones to the status register, usually the same value it just read. Software programs the mask through the enable register. The synchronised clear-to-send level is visible in a separate line-status vector.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the status register, the enable register and the line-status vector are all zero, and `irq_o` is low.
- R2: Status bit positions are fixed: 0 transmit holding empty, 1 receive data ready, 2 transmit FIFO almost empty, 3 transmit FIFO empty, 4 receive FIFO almost full, 5 receive FIFO full, 6 transmit underrun, 7 receive overrun, 8 parity error, 9 framing error, 10 clear-to-send change, 11 receive idle timeout, 12 break finished, 13 bus error response. A high `evt_i[k]` (k not 10) at a rising clock edge sets `status_o[k]` after that edge. The bit then stays set until it is cleared.
- R3: `irq_o` is high exactly when some bit is set in both `status_o` and `enable_o`. It follows the registers in the same cycle, with no extra register stage.
- R4: A write with `wr_sel_i`=0 (status) clears every status bit whose `wr_data_i` bit is 1. Bits written with 0 keep their value.
- R5: If an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R6: A write with `wr_sel_i`=1 (enable) loads `wr_data_i` into `enable_o`. A masked bit still sets in `status_o` but does not raise `irq_o`.
- R7: `cts_i` passes through two synchroniser flops. Each rising or falling change of the synchronised level sets `status_o[10]` three clock edges after the input change. `evt_i[10]` has no effect on the status register.
- R8: `line_stat_o[4]` shows the synchronised `cts_i` level two clock edges after an input change. All other line-status bits read 0.
- R9: No status bit becomes set unless its event input (or the clear-to-send change for bit 10) was active at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 14 | Event inputs, one per status bit (bit 10 unused) |
| cts_i | input | 1 | Asynchronous clear-to-send level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (write-one-to-clear), 1 enable |
| wr_data_i | input | 14 | Write data |
| status_o | output | 14 | Sticky status register |
| enable_o | output | 14 | Enable mask register |
| line_stat_o | output | 8 | Line status; bit 4 is the synchronised clear-to-send level |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
The set/clear path is driven with these patterns:
- Single-bit pulses on every source, which exposes any crossed bit.
- Multi-bit events against partial clear writes, which separates write-one-to-clear from plain writes.
- All-zero writes, which show that zeros are ignored.
- Simultaneous set and clear on one bit, which shows the priority.

The interrupt line is checked under masks that pass and that block a pending bit, which distinguishes a masked OR from a plain OR. The clear-to-send input is toggled in both directions, with samples taken before and after the synchroniser latency. This pins the cycle of the level and of the change bit, and shows that the direct event input for that bit is ignored.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int unsigned IRQ_SRC_N = 14;

   typedef enum int unsigned {
      SRC_TX_HOLD_EMPTY     = 0,
      SRC_RX_DATA_READY     = 1,
      SRC_TXF_ALMOST_EMPTY  = 2,
      SRC_TXF_EMPTY         = 3,
      SRC_RXF_ALMOST_FULL   = 4,
      SRC_RXF_FULL          = 5,
      SRC_TX_UNDERRUN       = 6,
      SRC_RX_OVERRUN        = 7,
      SRC_PARITY_ERR        = 8,
      SRC_FRAME_ERR         = 9,
      SRC_CTS_CHANGE        = 10,
      SRC_RX_IDLE_TIMEOUT   = 11,
      SRC_BREAK_FINISHED    = 12,
      SRC_BUS_ERR           = 13
   } irq_src_e;

   typedef enum logic {
      REG_STATUS = 1'b0,
      REG_ENABLE = 1'b1
   } irq_reg_sel_e;
endpackage

// File: rtl/uart_irq_cts_sync.sv
module uart_irq_cts_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic toggle_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("uart_irq_cts_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[LAST];
      end
   end

   assign level_o  = chain_q[LAST];
   assign toggle_o = chain_q[LAST] ^ prev_q;
endmodule

// File: rtl/uart_irq_status_bits.sv
module uart_irq_status_bits #(
   parameter int unsigned W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);
   for (genvar g = 0; g < W; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)        bit_q <= 1'b0;
         else if (set_i[g]) bit_q <= 1'b1;
         else if (clr_i[g]) bit_q <= 1'b0;
      end
      assign stat_o[g] = bit_q;
   end
endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine #(
   parameter int unsigned W = 14
) (
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   logic [W-1:0] pend;

   always_comb begin
      pend = stat_i & en_i;
   end

   assign irq_o = |pend;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC     = IRQ_SRC_N,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LSTAT_W     = 8,
   parameter int unsigned CTS_LVL_BIT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               cts_i,
   input  logic               wr_en_i,
   input  logic               wr_sel_i,
   input  logic [NUM_SRC-1:0] wr_data_i,
   output logic [NUM_SRC-1:0] status_o,
   output logic [NUM_SRC-1:0] enable_o,
   output logic [LSTAT_W-1:0] line_stat_o,
   output logic               irq_o
);
   localparam int unsigned CTS_POS = SRC_CTS_CHANGE;
   localparam logic [NUM_SRC-1:0] CTS_MASK = NUM_SRC'(1) << CTS_POS;

   if (NUM_SRC != IRQ_SRC_N) begin : g_bad_src
      $error("uart_irq_ctrl: the source map is fixed at 14 bits");
   end
   if (CTS_LVL_BIT >= LSTAT_W) begin : g_bad_lstat
      $error("uart_irq_ctrl: CTS_LVL_BIT outside line status");
   end

   logic               cts_level;
   logic               cts_toggle;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] enable_q;

   uart_irq_cts_sync #(.STAGES(SYNC_STAGES)) u_cts (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_i  (cts_i),
      .level_o  (cts_level),
      .toggle_o (cts_toggle)
   );

   always_comb begin
      set_vec = evt_i & ~CTS_MASK;
      set_vec[CTS_POS] = cts_toggle;
      clr_vec = (wr_en_i && (wr_sel_i == REG_STATUS)) ? wr_data_i : '0;
   end

   uart_irq_status_bits #(.W(NUM_SRC)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .stat_o (status_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         enable_q <= '0;
      else if (wr_en_i && (wr_sel_i == REG_ENABLE))
         enable_q <= wr_data_i;
   end
   assign enable_o = enable_q;

   for (genvar g = 0; g < LSTAT_W; g++) begin : g_lstat
      if (g == CTS_LVL_BIT) begin : g_cts
         assign line_stat_o[g] = cts_level;
      end else begin : g_zero
         assign line_stat_o[g] = 1'b0;
      end
   end

   uart_irq_combine #(.W(NUM_SRC)) u_comb (
      .stat_i (status_o),
      .en_i   (enable_q),
      .irq_o  (irq_o)
   );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
   parameter int unsigned NUM_SRC = 14,
   parameter int unsigned LSTAT_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               cts_i,
   input logic               wr_en_i,
   input logic               wr_sel_i,
   input logic [NUM_SRC-1:0] wr_data_i,
   input logic [NUM_SRC-1:0] status_o,
   input logic [NUM_SRC-1:0] enable_o,
   input logic [LSTAT_W-1:0] line_stat_o,
   input logic               irq_o
);
   localparam logic [NUM_SRC-1:0] CTS_M = NUM_SRC'(1) << 10;

   // R2: an event leaves its bit set after the edge
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & ~CTS_M) != '0) |=>
      ((status_o & $past(evt_i & ~CTS_M)) == $past(evt_i & ~CTS_M)));

   // R4: a status write clears written ones that had no event
   a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_sel_i && ((wr_data_i & ~evt_i & ~CTS_M) != '0)) |=>
      ((status_o & $past(wr_data_i & ~evt_i & ~CTS_M)) == '0));

   // R6: enable write loads the mask
   a_r6_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i) |=> (enable_o == $past(wr_data_i)));

   // R6: nothing enabled means no interrupt
   a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_o == '0) |-> !irq_o);

   // R7: a change of the synchronised level sets the change bit next edge
   a_r7_cts_change: assert property (@(posedge clk) disable iff (!rst_n)
      (line_stat_o[4] != $past(line_stat_o[4])) |=> status_o[10]);

   // R9: no non-CTS bit rises without its event
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((status_o & ~$past(status_o) & ~$past(evt_i) & ~CTS_M) == '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .LSTAT_W(LSTAT_W)) u_chk (.*);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] evt_i = '0;
   logic        cts_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic        wr_sel_i = 1'b0;
   logic [13:0] wr_data_i = '0;
   logic [13:0] status_o;
   logic [13:0] enable_o;
   logic [7:0]  line_stat_o;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   uart_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cts_i(cts_i),
      .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .status_o(status_o), .enable_o(enable_o), .line_stat_o(line_stat_o),
      .irq_o(irq_o)
   );

   typedef struct packed {
      logic [13:0] evt;
      logic        wr;
      logic [13:0] dat;
      logic [13:0] exp_st;
      logic        exp_irq;
   } vec_t;

   localparam int NV = 11;
   // enable mask is 0x0003 during the table walk
   localparam vec_t VEC [NV] = '{
      '{14'h0001, 1'b0, 14'h0000, 14'h0001, 1'b1},
      '{14'h0000, 1'b1, 14'h0001, 14'h0000, 1'b0},
      '{14'h2000, 1'b0, 14'h0000, 14'h2000, 1'b0},
      '{14'h0400, 1'b0, 14'h0000, 14'h2000, 1'b0},
      '{14'h0102, 1'b0, 14'h0000, 14'h2102, 1'b1},
      '{14'h0000, 1'b1, 14'h0100, 14'h2002, 1'b1},
      '{14'h0002, 1'b1, 14'h0002, 14'h2002, 1'b1},
      '{14'h0000, 1'b1, 14'h3FFF, 14'h0000, 1'b0},
      '{14'h00F0, 1'b0, 14'h0000, 14'h00F0, 1'b0},
      '{14'h0000, 1'b1, 14'h0000, 14'h00F0, 1'b0},
      '{14'h0000, 1'b1, 14'h00F0, 14'h0000, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, one posedge passes, return at next negedge with inputs idle
   task automatic step(input logic [13:0] evt, input logic wr, input logic sel,
                       input logic [13:0] dat);
      evt_i = evt; wr_en_i = wr; wr_sel_i = sel; wr_data_i = dat;
      @(negedge clk);
      evt_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", 32'(status_o), 0);
      chk("R1 enable", 32'(enable_o), 0);
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 line_stat", 32'(line_stat_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 enable load
      step('0, 1'b1, 1'b1, 14'h0003);
      chk("R6 enable load", 32'(enable_o), 32'h0003);
      chk("R3 idle irq", 32'(irq_o), 0);

      // table walk: R2 R3 R4 R5 R7
      for (int i = 0; i < NV; i++) begin
         step(VEC[i].evt, VEC[i].wr, 1'b0, VEC[i].dat);
         chk($sformatf("R2/R4/R5/R7 vec%0d status", i), 32'(status_o), 32'(VEC[i].exp_st));
         chk($sformatf("R3 vec%0d irq", i), 32'(irq_o), 32'(VEC[i].exp_irq));
      end

      // R2 walking single bits
      for (int b = 0; b < 14; b++) begin
         if (b != 10) begin
            step(14'(1) << b, 1'b0, 1'b0, '0);
            chk($sformatf("R2 bit%0d", b), 32'(status_o), 32'(14'(1) << b));
            step('0, 1'b1, 1'b0, 14'h3FFF);
         end
      end

      // R6 mask blocks, R3 level follows enable
      step('0, 1'b1, 1'b1, 14'h0000);
      step(14'h0001, 1'b0, 1'b0, '0);
      chk("R6 masked status", 32'(status_o), 32'h0001);
      chk("R6 masked irq", 32'(irq_o), 0);
      step('0, 1'b1, 1'b1, 14'h0001);
      chk("R3 irq after enable", 32'(irq_o), 1);
      @(negedge clk);
      chk("R3 irq level held", 32'(irq_o), 1);
      step('0, 1'b1, 1'b0, 14'h0001);
      chk("R4 clear drops irq", 32'(irq_o), 0);

      // R7 / R8 clear-to-send rise
      cts_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R8 cts level after sync", 32'(line_stat_o), 32'h10);
      chk("R7 change not yet set", 32'(status_o[10]), 0);
      @(negedge clk);
      chk("R7 change set on rise", 32'(status_o[10]), 1);
      step('0, 1'b1, 1'b0, 14'h0400);
      chk("R7 change cleared", 32'(status_o[10]), 0);
      // fall
      cts_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 cts level low", 32'(line_stat_o), 0);
      chk("R7 change set on fall", 32'(status_o), 32'h0400);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule